// File: doc/BRIEF.md
# SPI Write Tunnel over a Control-Frame Serial Link

This block lets a serial link carry a three-wire SPI write to a remote display controller. It does not decode the SPI traffic. The sending side watches the SPI clock, which arrives on control input 5. On each rising edge of that clock it captures all of the control-side pins as plain bits and sends them across one serial line as a control frame. These pins are the six control bits, the direction bit, the strobe-source select bit and a chip-select input. SPI data travels on control input 4.

The receiving side rebuilds the pins from each frame. The recovered SPI clock and data appear on control outputs 5 and 4. The same two signals are also copied onto data outputs 7 and 6, so that dual-mode displays have a second pinout. Each side has its own parallel/SPI mode pin, and tunnelling happens only when that pin is low.

The serial line has no back-pressure and no handshake. A new SPI clock edge that arrives while a frame is still on the line cannot be queued. That sample is dropped and a sticky overrun flag is raised.

Top module: `spi_ctl_tunnel`

## Requirements
- R1: After reset, `tx_line` idles high, `tx_ovr` is 0, and every receive output (`ctl_out`, `dir_out`, `sel_out`, `cs_out`, `dat_out`) is 0.
- R2: A frame is sent when all of the following hold: `tx_mode_par`=0, `sel_in`=0, and the transmitter is idle. Call the first clock edge that samples `ctl_in[5]` high (after it was low) edge 0. The start bit is then driven from edge 2.
- R2 (frame layout): A frame is 12 bits, and each bit lasts BIT_CYC clocks (2 by default). The bits are sent in this order:
  - start bit (0);
  - type bit (1);
  - nine payload bits, LSB first: `ctl_in[5:0]`, then `dir_in`, then `sel_in`, then `cs_in`;
  - stop bit (1).
- R2 (idle): After the stop bit, the line returns high.
- R3: While `tx_mode_par`=1, rising edges on `ctl_in[5]` produce no frame, and `tx_line` stays high.
- R4: While `sel_in`=1, rising edges on `ctl_in[5]` produce no frame, and `tx_line` stays high.
- R5: A rising edge that would start a frame while a frame is still in flight (up to and including the last stop-bit clock) is dropped. It also sets `tx_ovr`, which then stays set until reset.
- R6: The receiver samples each bit of an incoming frame. When the stop bit is sampled, and if the type bit was 1, the stop bit was 1 and `rx_mode_par`=0, the payload is loaded into `ctl_out`, `dir_out`, `sel_out` and `cs_out`. With `rx_mode_par`=1, these outputs hold their values. The load happens 11·BIT_CYC+1 clocks after the edge that drove the start bit.
- R7: With `rx_mode_par`=0, `dat_out[7]` equals `ctl_out[5]` (clock) and `dat_out[6]` equals `ctl_out[4]` (data), and all other `dat_out` bits are 0. With `rx_mode_par`=1, all of `dat_out` is 0.
- R8: Only rising edges of `ctl_in[5]` start frames. A falling edge sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low reset |
| tx_mode_par | input | 1 | Send-side mode, 0 = SPI tunnel |
| ctl_in | input | 6 | Control inputs; bit 5 is the SPI clock, bit 4 the SPI data |
| dir_in | input | 1 | Direction bit, forwarded |
| sel_in | input | 1 | Strobe-source select; tunnel runs only when 0 |
| cs_in | input | 1 | Secondary strobe, wired to SPI chip select |
| tx_line | output | 1 | Serial line out, idle high |
| tx_ovr | output | 1 | Sticky overrun flag |
| rx_mode_par | input | 1 | Receive-side mode, 0 = SPI tunnel |
| rx_line | input | 1 | Serial line in |
| ctl_out | output | 6 | Recovered control bits |
| dir_out | output | 1 | Recovered direction bit |
| sel_out | output | 1 | Recovered select bit |
| cs_out | output | 1 | Recovered chip select |
| dat_out | output | 18 | Data pins; bits 7/6 duplicate the SPI clock/data |

## Verification
The first test sends slow SPI clock pulses that carry varied data, chip-select and direction patterns. This shows whether the payload bit order and the duplicate pin mapping survive the round trip. Further clock edges are sent with the send-side mode set to parallel, and again with the select bit set to 1. These show that each gate alone blocks frame generation. A long high phase followed by a falling edge separates rising-edge detection from level detection. A frame received while the receive side is in parallel mode checks that the outputs hold. Last, clock pulses faster than a frame lasts check the overrun drop and the sticky flag.

// File: rtl/spi_tun_pkg.sv
package spi_tun_pkg;
  localparam logic TYPE_CTRL = 1'b1;
  localparam logic START_LVL = 1'b0;
  localparam logic STOP_LVL  = 1'b1;
  typedef enum logic {RX_IDLE, RX_BITS} rx_state_e;
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its delayed copy
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], async_in};
  end

  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/spi_frame_tx.sv
module spi_frame_tx
  import spi_tun_pkg::*;
#(
  parameter int PL_W    = 9,
  parameter int BIT_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic [PL_W-1:0] payload,
  output logic            line,
  output logic            busy,
  output logic            overrun
);
  localparam int FB = PL_W + 3;
  localparam int CW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int IW = $clog2(FB);

  logic [FB-1:0] frame_w;
  logic [FB-1:0] sh;
  logic [CW-1:0] cyc;
  logic [IW-1:0] idx;

  assign frame_w = {STOP_LVL, payload, TYPE_CTRL, START_LVL};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line    <= 1'b1;
      busy    <= 1'b0;
      overrun <= 1'b0;
      sh      <= '0;
      cyc     <= '0;
      idx     <= '0;
    end else begin
      if (go && busy) overrun <= 1'b1;
      if (!busy) begin
        if (go) begin
          line <= frame_w[0];
          sh   <= frame_w >> 1;
          busy <= 1'b1;
          cyc  <= '0;
          idx  <= '0;
        end
      end else if (cyc == CW'(BIT_CYC - 1)) begin
        cyc <= '0;
        if (idx == IW'(FB - 1)) begin
          busy <= 1'b0;
          line <= 1'b1;
        end else begin
          idx  <= idx + 1'b1;
          line <= sh[0];
          sh   <= sh >> 1;
        end
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_tun_pkg::*;
#(
  parameter int PL_W    = 9,
  parameter int BIT_CYC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            line,
  input  logic            enable,
  output logic [PL_W-1:0] word
);
  localparam int FB = PL_W + 3;
  localparam int SW = FB - 1;
  localparam int CW = (BIT_CYC > 1) ? $clog2(BIT_CYC) : 1;
  localparam int IW = $clog2(FB);

  rx_state_e     st;
  logic [CW-1:0] cyc;
  logic [IW-1:0] idx;
  logic [SW-1:0] sh, nxt;

  // after the last sample: nxt[0] = type, nxt[SW-1] = stop
  assign nxt = {line, sh[SW-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= RX_IDLE;
      cyc  <= '0;
      idx  <= '0;
      sh   <= '0;
      word <= '0;
    end else begin
      case (st)
        RX_IDLE: if (line == START_LVL) begin
          st  <= RX_BITS;
          cyc <= '0;
          idx <= '0;
        end
        default: begin
          if (cyc == CW'(BIT_CYC - 1)) begin
            cyc <= '0;
            sh  <= nxt;
            if (idx == IW'(SW - 1)) begin
              st <= RX_IDLE;
              if (enable && nxt[SW-1] == STOP_LVL && nxt[0] == TYPE_CTRL)
                word <= nxt[PL_W:1];
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/spi_ctl_tunnel.sv
module spi_ctl_tunnel #(
  parameter int CTL_W   = 6,
  parameter int DAT_W   = 18,
  parameter int BIT_CYC = 2,
  parameter int SYNC_ST = 2,
  parameter int CLK_IDX = 5,
  parameter int SDA_IDX = 4,
  parameter int DUP_CLK = 7,
  parameter int DUP_SDA = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_mode_par,
  input  logic [CTL_W-1:0] ctl_in,
  input  logic             dir_in,
  input  logic             sel_in,
  input  logic             cs_in,
  output logic             tx_line,
  output logic             tx_ovr,
  input  logic             rx_mode_par,
  input  logic             rx_line,
  output logic [CTL_W-1:0] ctl_out,
  output logic             dir_out,
  output logic             sel_out,
  output logic             cs_out,
  output logic [DAT_W-1:0] dat_out
);
  localparam int PL_W = CTL_W + 3;

  logic            sclk_rise, go, tx_busy;
  logic [PL_W-1:0] rx_word;

  spi_edge_sync #(.STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ctl_in[CLK_IDX]), .rise(sclk_rise)
  );

  assign go = sclk_rise & ~tx_mode_par & ~sel_in;

  spi_frame_tx #(.PL_W(PL_W), .BIT_CYC(BIT_CYC)) u_tx (
    .clk(clk), .rst_n(rst_n), .go(go),
    .payload({cs_in, sel_in, dir_in, ctl_in}),
    .line(tx_line), .busy(tx_busy), .overrun(tx_ovr)
  );

  spi_frame_rx #(.PL_W(PL_W), .BIT_CYC(BIT_CYC)) u_rx (
    .clk(clk), .rst_n(rst_n), .line(rx_line), .enable(~rx_mode_par),
    .word(rx_word)
  );

  assign ctl_out = rx_word[CTL_W-1:0];
  assign dir_out = rx_word[CTL_W];
  assign sel_out = rx_word[CTL_W+1];
  assign cs_out  = rx_word[CTL_W+2];

  for (genvar i = 0; i < DAT_W; i++) begin : g_dat
    if (i == DUP_CLK) begin : g_clk
      assign dat_out[i] = ~rx_mode_par & rx_word[CLK_IDX];
    end else if (i == DUP_SDA) begin : g_sda
      assign dat_out[i] = ~rx_mode_par & rx_word[SDA_IDX];
    end else begin : g_zero
      assign dat_out[i] = 1'b0;
    end
  end
endmodule

// File: rtl/spi_ctl_tunnel_chk.sv
module spi_ctl_tunnel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_mode_par,
  input logic        sel_in,
  input logic        tx_line,
  input logic        tx_busy,
  input logic        tx_ovr,
  input logic        rx_mode_par,
  input logic [5:0]  ctl_out,
  input logic [17:0] dat_out
);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_line);

  assert_par_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && tx_mode_par) |=> tx_line);

  assert_sel_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && sel_in) |=> tx_line);

  assert_ovr_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ovr |=> tx_ovr);

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode_par |=> $stable(ctl_out));

  assert_dat_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_out & ~18'h000C0) == 18'h0);
endmodule

bind spi_ctl_tunnel spi_ctl_tunnel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_mode_par(tx_mode_par), .sel_in(sel_in),
  .tx_line(tx_line), .tx_busy(tx_busy), .tx_ovr(tx_ovr),
  .rx_mode_par(rx_mode_par), .ctl_out(ctl_out), .dat_out(dat_out)
);

// File: tb/spi_ctl_tunnel_bench.sv
module spi_ctl_tunnel_bench;
  localparam int BC = 2;

  logic clk = 0, rst_n = 0;
  logic tx_mode_par = 0, dir_in = 0, sel_in = 0, cs_in = 0, rx_mode_par = 0;
  logic [5:0] ctl_in = 0;
  logic tx_line, tx_ovr, dir_out, sel_out, cs_out;
  logic [5:0] ctl_out;
  logic [17:0] dat_out;

  always #10 clk = ~clk;

  spi_ctl_tunnel u_spi_ctl_tunnel (
    .clk(clk), .rst_n(rst_n), .tx_mode_par(tx_mode_par), .ctl_in(ctl_in),
    .dir_in(dir_in), .sel_in(sel_in), .cs_in(cs_in), .tx_line(tx_line),
    .tx_ovr(tx_ovr), .rx_mode_par(rx_mode_par), .rx_line(tx_line),
    .ctl_out(ctl_out), .dir_out(dir_out), .sel_out(sel_out), .cs_out(cs_out),
    .dat_out(dat_out)
  );

  int checks = 0, errors = 0, lows = 0;
  bit done = 0;

  // behavioural reference model
  int q[$];
  bit m_s1, m_s2, m_s2d, in_frame, exp_line = 1, exp_ovr, rise;
  int pend;
  logic [8:0] pend_pl, exp_word;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_s1 = 0; m_s2 = 0; m_s2d = 0; in_frame = 0;
      exp_line = 1; exp_ovr = 0; pend = 0; exp_word = 0; pend_pl = 0;
    end else begin
      rise = m_s2 && !m_s2d;
      if (pend > 0) begin
        pend--;
        if (pend == 0 && !rx_mode_par) exp_word = pend_pl;
      end
      if (rise && !tx_mode_par && !sel_in) begin
        if (in_frame) exp_ovr = 1;
        else begin
          logic [11:0] fr;
          fr = {1'b1, cs_in, sel_in, dir_in, ctl_in, 1'b1, 1'b0};
          for (int b = 0; b < 12; b++)
            for (int c = 0; c < BC; c++) q.push_back(int'(fr[b]));
          pend = 11 * BC + 1;
          pend_pl = fr[10:2];
        end
      end
      if (q.size() > 0) begin exp_line = q.pop_front()[0]; in_frame = 1; end
      else begin exp_line = 1; in_frame = 0; end
      m_s2d = m_s2; m_s2 = m_s1; m_s1 = ctl_in[5];
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [17:0] ed;
    if (tx_line == 0) lows++;
    ed = 0;
    if (!rx_mode_par) begin ed[7] = exp_word[5]; ed[6] = exp_word[4]; end
    chk(tx_line == exp_line, "R2 line", tx_line, exp_line);
    chk(tx_ovr == exp_ovr, "R5 ovr", tx_ovr, exp_ovr);
    chk({cs_out, sel_out, dir_out, ctl_out} == exp_word, "R6 word",
        {cs_out, sel_out, dir_out, ctl_out}, exp_word);
    chk(dat_out == ed, "R7 dat", dat_out, ed);
  end

  task automatic waitc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic pulse(input logic [4:0] lo5, input bit d, input bit s,
                       input bit cs, input int hi, input int lo);
    ctl_in = {1'b0, lo5}; dir_in = d; sel_in = s; cs_in = cs;
    waitc(2);
    ctl_in[5] = 1; waitc(hi);
    ctl_in[5] = 0; waitc(lo);
  endtask

  initial begin
    #200000;
    $display("FAIL watchdog expired");
    errors++; checks++;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    waitc(3);
    rst_n = 1;
    waitc(1);
    // R1 reset state
    chk(tx_line == 1 && tx_ovr == 0, "R1 tx", {tx_line, tx_ovr}, 2);
    chk({cs_out, sel_out, dir_out, ctl_out} == 0 && dat_out == 0, "R1 rx",
        {cs_out, sel_out, dir_out, ctl_out}, 0);
    // R2 R6 R7 varied patterns
    pulse(5'h10, 1, 0, 1, 30, 6);
    chk(ctl_out == 6'h30 && cs_out && dir_out, "R6 pattern A", ctl_out, 6'h30);
    chk(dat_out == 18'h0C0, "R7 pattern A", dat_out, 18'h0C0);
    pulse(5'h0F, 0, 0, 0, 30, 6);
    chk(ctl_out == 6'h2F && !cs_out && !dir_out, "R6 pattern B", ctl_out, 6'h2F);
    chk(dat_out == 18'h080, "R7 pattern B", dat_out, 18'h080);
    pulse(5'h15, 1, 0, 0, 30, 6);
    chk(ctl_out == 6'h35, "R6 pattern C", ctl_out, 6'h35);
    // R3 parallel send mode
    tx_mode_par = 1; lows = 0;
    pulse(5'h1F, 0, 0, 1, 30, 30);
    chk(lows == 0, "R3 no frame", lows, 0);
    tx_mode_par = 0;
    // R4 select bit set
    lows = 0;
    pulse(5'h01, 0, 1, 1, 30, 30);
    chk(lows == 0, "R4 no frame", lows, 0);
    // R8 falling edge sends nothing
    ctl_in = 6'h0A; sel_in = 0; waitc(2);
    ctl_in[5] = 1; waitc(40);
    lows = 0;
    ctl_in[5] = 0; waitc(40);
    chk(lows == 0, "R8 falling edge", lows, 0);
    // R6 receive side in parallel mode holds
    rx_mode_par = 1;
    pulse(5'h03, 1, 0, 0, 30, 6);
    chk(ctl_out == 6'h2A, "R6 hold", ctl_out, 6'h2A);
    chk(dat_out == 0, "R7 par zero", dat_out, 0);
    rx_mode_par = 0; waitc(2);
    // R5 overrun with fast clock
    for (int k = 0; k < 6; k++) pulse(5'(k), 0, 0, 0, 3, 1);
    waitc(40);
    chk(tx_ovr == 1, "R5 overrun", tx_ovr, 1);
    waitc(5);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule